// File: doc/BRIEF.md
# Event-Driven Pin Link Bank

This block ties individual pins of two 8-bit port groups to an on-chip event network. It holds a bank of four channels. Each channel is set up through its own 8-bit configuration register, which picks a port group, a bit inside that group and a link mode. The direction of each pin comes from an external per-pin direction input, and that input decides how the channel behaves.

When the selected pin is an output, an event pulse arriving on the channel's event input clears the pin's output latch, sets it, or inverts it. When the selected pin is an input, the pin level passes through a two-stage synchronizer. The channel then watches for a rising edge, a falling edge or either edge, and emits a one-cycle event pulse when the chosen edge appears. The output latches for both groups belong to the block. Pad drivers, the routing of events between blocks and the bus that writes the registers are all outside it.

Top module: `evlink_port_ctrl`

## Requirements
- R1: After reset every configuration register reads 0x80, both output groups read 0x00 and no event output is active.
- R2: Configuration register layout: bits [2:0] are the pin index inside the group, bits [4:3] are the group select and bits [6:5] are the mode. A write stores bits [6:0]. Bit 7 always reads 1, whatever value is written to it.
- R3: A group select of 00 or 11 disables the channel. A disabled channel emits no event and changes no output latch, and the latches keep their values.
- R4: Group select 01 picks group 0 and 10 picks group 1. For a pin whose direction bit is 1 (output), an event-input pulse with mode 00 clears the latch bit and with mode 01 sets it. The new value shows on the output after the clock edge that samples the pulse.
- R5: For an output pin, an event with mode 10 or 11 inverts the latch bit once per event.
- R6: For a pin whose direction bit is 0 (input), mode 00 flags rising edges, 01 flags falling edges and 1x flags both. The event output goes high for exactly one cycle after the third rising clock edge that follows the pin change.
- R7: Pin direction is taken only from the direction inputs. An output-type action never alters a latch bit whose direction is 0, and edge detection never fires on a pin whose direction is 1.
- R8: A configuration write never by itself creates an event, even when the newly selected pin's level differs from the old one.
- R9: When several channels act on the same output pin in one cycle, the highest-numbered channel decides the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration register picked by cfg_addr |
| cfg_addr | input | 2 | Channel index for write and read |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the addressed register (combinational) |
| ev_in | input | 4 | One event-input pulse per channel |
| ev_out | output | 4 | One generated event pulse per channel |
| gp0_in | input | 8 | Pin levels, group 0 (asynchronous) |
| gp1_in | input | 8 | Pin levels, group 1 (asynchronous) |
| gp0_dir | input | 8 | Direction per pin of group 0, 1 = output |
| gp1_dir | input | 8 | Direction per pin of group 1, 1 = output |
| gp0_out | output | 8 | Output latches, group 0 |
| gp1_out | output | 8 | Output latches, group 1 |

## Verification
Readback is combinational, so it is sampled shortly after the address is driven. An output-latch change is due one clock edge after the event-input pulse, and the bench checks it at the next falling edge. A generated event passes through two synchronizer stages and one event register, so after every pin change the bench samples the event outputs at five falling edges in a row. It expects the pulse only in the third of those samples and nowhere else, which catches pulses that arrive early, late or stretched.

// File: rtl/evlink_pkg.sv
package evlink_pkg;

  localparam int unsigned PORT_W = 8;
  localparam int unsigned BIT_W  = $clog2(PORT_W);

  typedef enum logic [1:0] {
    GSEL_OFF  = 2'b00,
    GSEL_G0   = 2'b01,
    GSEL_G1   = 2'b10,
    GSEL_BAD  = 2'b11
  } gsel_e;

  // stored part of a channel register, bit 7 is not stored
  typedef struct packed {
    logic [1:0]       mode;
    gsel_e            gsel;
    logic [BIT_W-1:0] pin;
  } chan_cfg_t;

  // output-pin action requested by one channel
  typedef struct packed {
    logic             vld;
    logic             grp;
    logic [BIT_W-1:0] pin;
    logic [1:0]       mode;
  } out_req_t;

  function automatic logic cfg_enabled(input chan_cfg_t c);
    return (c.gsel == GSEL_G0) || (c.gsel == GSEL_G1);
  endfunction

endpackage

// File: rtl/evlink_sync.sv
module evlink_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stg1_q;
  logic [W-1:0] stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= async_i;
      stg2_q <= stg1_q;
    end
  end

  assign sync_o = stg2_q;

endmodule

// File: rtl/evlink_chan.sv
module evlink_chan
  import evlink_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [6:0]        wr_data,
  input  logic [PORT_W-1:0] g0_lvl,
  input  logic [PORT_W-1:0] g1_lvl,
  input  logic [PORT_W-1:0] g0_dir,
  input  logic [PORT_W-1:0] g1_dir,
  input  logic              ev_in,
  output chan_cfg_t         cfg_o,
  output logic              ev_out,
  output out_req_t          req_o
);

  chan_cfg_t cfg_q, cfg_d, cfg_new;
  logic      hist_q, hist_d;
  logic      ev_q, ev_d;
  logic      cur_lvl, new_lvl, cur_dir, en;
  logic      rise, fall, hit;

  function automatic logic pick(input chan_cfg_t c, input logic [PORT_W-1:0] a,
                                input logic [PORT_W-1:0] b);
    return (c.gsel == GSEL_G1) ? b[c.pin] : a[c.pin];
  endfunction

  assign cfg_new = chan_cfg_t'(wr_data);

  always_comb begin
    en      = cfg_enabled(cfg_q);
    cur_lvl = pick(cfg_q, g0_lvl, g1_lvl);
    cur_dir = pick(cfg_q, g0_dir, g1_dir);
    new_lvl = pick(cfg_new, g0_lvl, g1_lvl);
    rise    = cur_lvl & ~hist_q;
    fall    = ~cur_lvl & hist_q;
    hit     = 1'b0;
    if (en && !cur_dir && !wr_en) begin
      if (cfg_q.mode[1])      hit = rise | fall;
      else if (cfg_q.mode[0]) hit = fall;
      else                    hit = rise;
    end
    // a write reloads the history with the level of the newly chosen pin
    hist_d = wr_en ? new_lvl : cur_lvl;
    cfg_d  = wr_en ? cfg_new : cfg_q;
    ev_d   = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      hist_q <= 1'b0;
      ev_q   <= 1'b0;
    end else begin
      if (wr_en) cfg_q <= cfg_d;
      hist_q <= hist_d;
      ev_q   <= ev_d;
    end
  end

  always_comb begin
    req_o.vld  = en & cur_dir & ev_in;
    req_o.grp  = (cfg_q.gsel == GSEL_G1);
    req_o.pin  = cfg_q.pin;
    req_o.mode = cfg_q.mode;
  end

  assign cfg_o  = cfg_q;
  assign ev_out = ev_q;

endmodule

// File: rtl/evlink_merge.sv
module evlink_merge
  import evlink_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  out_req_t          req_i [NUM_CH],
  output logic [PORT_W-1:0] g0_out,
  output logic [PORT_W-1:0] g1_out
);

  logic [PORT_W-1:0] g0_q, g0_d, g1_q, g1_d;
  logic              upd_en;

  // ascending scan: the last (highest) channel writing a bit wins
  always_comb begin
    g0_d   = g0_q;
    g1_d   = g1_q;
    upd_en = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (req_i[c].vld) begin
        upd_en = 1'b1;
        if (req_i[c].grp)
          g1_d[req_i[c].pin] = req_i[c].mode[1] ? ~g1_q[req_i[c].pin] : req_i[c].mode[0];
        else
          g0_d[req_i[c].pin] = req_i[c].mode[1] ? ~g0_q[req_i[c].pin] : req_i[c].mode[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g0_q <= '0;
      g1_q <= '0;
    end else if (upd_en) begin
      g0_q <= g0_d;
      g1_q <= g1_d;
    end
  end

  assign g0_out = g0_q;
  assign g1_out = g1_q;

endmodule

// File: rtl/evlink_port_ctrl.sv
module evlink_port_ctrl
  import evlink_pkg::*;
#(
  parameter  int unsigned NUM_CH = 4,
  localparam int unsigned ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [NUM_CH-1:0] ev_in,
  output logic [NUM_CH-1:0] ev_out,
  input  logic [PORT_W-1:0] gp0_in,
  input  logic [PORT_W-1:0] gp1_in,
  input  logic [PORT_W-1:0] gp0_dir,
  input  logic [PORT_W-1:0] gp1_dir,
  output logic [PORT_W-1:0] gp0_out,
  output logic [PORT_W-1:0] gp1_out
);

  logic [2*PORT_W-1:0] lvl_sync;
  chan_cfg_t           cfg_arr [NUM_CH];
  out_req_t            req_arr [NUM_CH];
  logic                unused_wbit;

  assign unused_wbit = cfg_wdata[7];

  evlink_sync #(.W(2*PORT_W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({gp1_in, gp0_in}),
    .sync_o  (lvl_sync)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    evlink_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we && (int'(cfg_addr) == g)),
      .wr_data (cfg_wdata[6:0]),
      .g0_lvl  (lvl_sync[PORT_W-1:0]),
      .g1_lvl  (lvl_sync[2*PORT_W-1:PORT_W]),
      .g0_dir  (gp0_dir),
      .g1_dir  (gp1_dir),
      .ev_in   (ev_in[g]),
      .cfg_o   (cfg_arr[g]),
      .ev_out  (ev_out[g]),
      .req_o   (req_arr[g])
    );
  end

  evlink_merge #(.NUM_CH(NUM_CH)) u_merge (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_arr),
    .g0_out (gp0_out),
    .g1_out (gp1_out)
  );

  always_comb begin
    cfg_rdata = 8'h80;
    for (int c = 0; c < NUM_CH; c++)
      if (int'(cfg_addr) == c) cfg_rdata = {1'b1, cfg_arr[c]};
  end

endmodule

// File: rtl/evlink_port_ctrl_chk.sv
module evlink_port_ctrl_chk #(
  parameter  int unsigned NUM_CH = 4,
  parameter  int unsigned PW     = 8,
  localparam int unsigned ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [7:0]        cfg_rdata,
  input logic [NUM_CH-1:0] ev_in,
  input logic [NUM_CH-1:0] ev_out,
  input logic [PW-1:0]     gp0_dir,
  input logic [PW-1:0]     gp1_dir,
  input logic [PW-1:0]     gp0_out,
  input logic [PW-1:0]     gp1_out
);

  // R2
  rd_topbit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[7] == 1'b1);

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(|ev_in) |-> ($stable(gp0_out) && $stable(gp1_out)));

  // R7
  dir_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((gp0_out ^ $past(gp0_out)) & ~$past(gp0_dir)) == '0) &&
    (((gp1_out ^ $past(gp1_out)) & ~$past(gp1_dir)) == '0));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_wr
    // R8
    wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && (int'(cfg_addr) == g)) |=> !ev_out[g]);
  end

endmodule

bind evlink_port_ctrl evlink_port_ctrl_chk #(.NUM_CH(NUM_CH), .PW(evlink_pkg::PORT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_rdata (cfg_rdata),
  .ev_in     (ev_in),
  .ev_out    (ev_out),
  .gp0_dir   (gp0_dir),
  .gp1_dir   (gp1_dir),
  .gp0_out   (gp0_out),
  .gp1_out   (gp1_out)
);

// File: tb/evlink_port_ctrl_bench.sv
`timescale 1ns/1ps
module evlink_port_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [1:0] cfg_addr;
  logic [7:0] cfg_wdata, cfg_rdata;
  logic [3:0] ev_in, ev_out;
  logic [7:0] gp0_in, gp1_in, gp0_dir, gp1_dir, gp0_out, gp1_out;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] shadow [4];
  logic [7:0] m0, m1;

  always #10 clk = ~clk;

  evlink_port_ctrl u_evlink_port_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ev_in(ev_in), .ev_out(ev_out),
    .gp0_in(gp0_in), .gp1_in(gp1_in), .gp0_dir(gp0_dir), .gp1_dir(gp1_dir),
    .gp0_out(gp0_out), .gp1_out(gp1_out)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int ch, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = 2'(ch); cfg_wdata = d;
    shadow[ch] = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic rd_check(input int ch, input logic [7:0] exp, input string req);
    cfg_addr = 2'(ch);
    #1;
    check(cfg_rdata == exp, req, cfg_rdata, exp);
  endtask

  task automatic fire(input logic [3:0] m);
    ev_in = m;
    tick();
    ev_in = '0;
  endtask

  // expected latch update for one event vector, highest channel last
  function automatic void model_fire(input logic [3:0] m, input logic [7:0] d0,
                                     input logic [7:0] d1);
    logic [7:0] n0, n1;
    n0 = m0; n1 = m1;
    for (int c = 0; c < 4; c++) begin
      logic [1:0] gs; logic [2:0] p; logic [1:0] md;
      gs = shadow[c][4:3]; p = shadow[c][2:0]; md = shadow[c][6:5];
      if (m[c] && gs == 2'b01 && d0[p]) n0[p] = md[1] ? ~m0[p] : md[0];
      if (m[c] && gs == 2'b10 && d1[p]) n1[p] = md[1] ? ~m1[p] : md[0];
    end
    m0 = n0; m1 = n1;
  endfunction

  // pin already changed; expect pulse only at the third sample
  task automatic pulse_check(input int ch, input bit exp_pulse, input string req);
    for (int k = 1; k <= 5; k++) begin
      logic [3:0] e;
      tick();
      e = (k == 3 && exp_pulse) ? 4'(1 << ch) : 4'h0;
      check(ev_out == e, req, ev_out, e);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; ev_in = 0;
    gp0_in = 0; gp1_in = 0; gp0_dir = 0; gp1_dir = 0;
    for (int c = 0; c < 4; c++) shadow[c] = 8'h80;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R1 reset state
    for (int c = 0; c < 4; c++) rd_check(c, 8'h80, "R1 reset readback");
    check(gp0_out == 0 && gp1_out == 0, "R1 outputs", {gp1_out, gp0_out}, 0);
    check(ev_out == 0, "R1 ev_out", ev_out, 0);

    // R2 layout and reserved bit
    wr(2, 8'h15); rd_check(2, 8'h95, "R2 bit7 written 0");
    wr(2, 8'h7F); rd_check(2, 8'hFF, "R2 all fields");
    wr(2, 8'h80); rd_check(2, 8'h80, "R2 restore");

    // R4 set and clear on group 0 pin 2 and group 1 pin 7
    gp0_dir = 8'hFF; gp1_dir = 8'hFF;
    wr(0, 8'hAA); fire(4'b0001);
    check(gp0_out == 8'h04, "R4 set g0", gp0_out, 8'h04);
    wr(0, 8'h8A); fire(4'b0001);
    check(gp0_out == 8'h00, "R4 clear g0", gp0_out, 8'h00);
    wr(1, 8'hB7); fire(4'b0010);
    check(gp1_out == 8'h80, "R4 set g1", gp1_out, 8'h80);

    // R5 toggle
    wr(0, 8'hCA); fire(4'b0001);
    check(gp0_out == 8'h04, "R5 toggle up", gp0_out, 8'h04);
    fire(4'b0001);
    check(gp0_out == 8'h00, "R5 toggle down", gp0_out, 8'h00);

    // R3 disabled selects 00 and 11
    wr(1, 8'hA7); fire(4'b0010);
    check(gp1_out == 8'h80 && gp0_out == 0, "R3 sel 00", {gp1_out, gp0_out}, 16'h8000);
    wr(1, 8'hDF); fire(4'b0010);
    check(gp1_out == 8'h80 && gp0_out == 0, "R3 sel 11", {gp1_out, gp0_out}, 16'h8000);

    // R7 output action blocked on input-direction pin
    gp0_dir = 8'hFB; fire(4'b0001);
    check(gp0_out == 8'h00, "R7 dir gate", gp0_out, 8'h00);
    gp0_dir = 8'hFF;

    // R9 priority, two channels on group 0 pin 0
    wr(1, 8'hA8); wr(2, 8'h88); fire(4'b0110);
    check(gp0_out[0] == 1'b0, "R9 high clears", gp0_out, 0);
    wr(1, 8'h88); wr(2, 8'hA8); fire(4'b0110);
    check(gp0_out[0] == 1'b1, "R9 high sets", gp0_out, 1);

    // R4 R5 R9 random event traffic against the bench model
    m0 = gp0_out; m1 = gp1_out;
    for (int i = 0; i < 400; i++) begin
      logic [3:0] m;
      if (i % 25 == 0) begin
        for (int c = 0; c < 4; c++) wr(c, 8'($urandom));
        gp0_dir = 8'($urandom); gp1_dir = 8'($urandom);
      end
      m = 4'($urandom);
      model_fire(m, gp0_dir, gp1_dir);
      fire(m);
      check(gp0_out == m0 && gp1_out == m1, "R4 R5 R9 random",
            {gp1_out, gp0_out}, {m1, m0});
    end

    // input side
    ev_in = 0; gp0_dir = 0; gp1_dir = 0; gp0_in = 0; gp1_in = 0;
    for (int c = 0; c < 4; c++) wr(c, 8'h80);
    repeat (4) tick();

    // R6 rising on group 0 pin 3
    wr(0, 8'h8B); repeat (3) tick();
    gp0_in[3] = 1'b1; pulse_check(0, 1, "R6 rise");
    gp0_in[3] = 1'b0; pulse_check(0, 0, "R6 rise ignores fall");
    wr(0, 8'hAB); repeat (3) tick();
    gp0_in[3] = 1'b1; pulse_check(0, 0, "R6 fall ignores rise");
    gp0_in[3] = 1'b0; pulse_check(0, 1, "R6 fall");
    wr(0, 8'hCB); repeat (3) tick();
    gp0_in[3] = 1'b1; pulse_check(0, 1, "R6 both up");
    gp0_in[3] = 1'b0; pulse_check(0, 1, "R6 both down");
    wr(3, 8'h95); repeat (3) tick();
    gp1_in[5] = 1'b1; pulse_check(3, 1, "R6 group 1 rise");

    // R3 disabled channel emits nothing
    wr(0, 8'hC3); repeat (3) tick();
    gp0_in[3] = 1'b1; pulse_check(0, 0, "R3 sel 00 input");
    wr(0, 8'hDB); repeat (3) tick();
    gp0_in[3] = 1'b0; pulse_check(0, 0, "R3 sel 11 input");

    // R7 output-direction pin never detected
    wr(0, 8'hCB); gp0_dir[3] = 1'b1; repeat (3) tick();
    gp0_in[3] = 1'b1; pulse_check(0, 0, "R7 no detect on output");
    gp0_dir[3] = 1'b0;

    // R8 reselect onto pin of different level
    gp0_in[4] = 1'b0; repeat (4) tick();
    wr(0, 8'h8C); repeat (3) tick();
    cfg_we = 1'b1; cfg_addr = 0; cfg_wdata = 8'h8B; tick(); cfg_we = 1'b0;
    check(ev_out == 0, "R8 write cycle", ev_out, 0);
    pulse_check(0, 0, "R8 reselect rising");
    wr(0, 8'hAC);
    pulse_check(0, 0, "R8 reselect falling");

    finish_run();
  end

endmodule